// File: doc/BRIEF.md
# I/O Write Snoop Relocation Sequencer

This block lets a device learn its I/O base address with no jumpers and no prior configuration. After a mode-entry request, the block goes into a relocatable mode. In that mode it answers no bus cycle at all. It only watches the I/O writes that other agents complete. It waits for an unbroken run of twelve byte writes to the well-known port 0x378. The first four bytes are a fixed signature. The remaining eight supply a 32-bit base address and two 16-bit configuration words.

When the twelfth write has been taken, the block leaves the mode. From then on it flags every I/O access that falls in the 32-byte window starting at the captured base. Outside the mode, software may also load the base address through a direct write port. That port is locked while the mode is active.

Top module: `io_reloc_snoop`

## Requirements
- R1: After reset the mode flag is low, the base address and both configuration words read zero, and `win_hit` is low.
- R2: A pulse on `mode_req` sets `reloc_mode` at the next clock edge and restarts the sequence from its first write. This happens whatever else occurs in that cycle.
- R3: In the mode, a qualifying write is an access cycle (`io_dp` high) with `io_wr` high, a port address match and `bus_be[0]` high. The first four qualifying writes advance the sequence only if `bus_wdata[7:0]` equals 0x41, 0x4D, 0x44 and 0x01 in turn. `bus_be[3:1]` and `bus_wdata[31:8]` have no effect.
- R4: In the mode, any access cycle that is not a qualifying write restarts the sequence at the first signature byte. This covers another address, a read of the port, and a port write with `bus_be[0]` low.
- R5: A signature byte that mismatches restarts the sequence, unless the byte is 0x41. A mismatching 0x41 counts as the first signature byte.
- R6: Qualifying writes 5 to 12 load, in that order: `io_base[7:0]`, `io_base[15:8]`, `io_base[23:16]`, `io_base[31:24]`, `cfg_a[7:0]`, `cfg_a[15:8]`, `cfg_b[7:0]` and `cfg_b[15:8]`.
- R7: With `addr_full` low, only `bus_addr[23:0]` is compared with 0x378. With `addr_full` high, all 32 bits are compared.
- R8: `reloc_mode` falls at the clock edge that takes the twelfth write. Outside the mode, `win_hit` is high during an access cycle exactly when `bus_addr - io_base` (modulo 2^32) is below 32.
- R9: While `reloc_mode` is high, `win_hit` stays low.
- R10: A direct write (`dir_we`) loads `dir_data` into `io_base[15:0]` when `dir_sel` is 0, and into `io_base[31:16]` when `dir_sel` is 1. It takes effect only while `reloc_mode` is low.
- R11: Each access cycle moves the sequence forward by at most one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 32 | I/O address of the current access |
| bus_be | input | 4 | Byte enables, active high |
| bus_wdata | input | 32 | Write data |
| io_wr | input | 1 | High for a write access, low for a read |
| io_dp | input | 1 | First data-phase cycle of an I/O access, one cycle per access |
| mode_req | input | 1 | Request to enter relocatable mode |
| addr_full | input | 1 | 1: compare 32 address bits, 0: compare 24 |
| dir_we | input | 1 | Direct base register write strobe |
| dir_sel | input | 1 | Direct write half: 0 low, 1 high |
| dir_data | input | 16 | Direct write data |
| reloc_mode | output | 1 | Relocatable mode flag |
| io_base | output | 32 | Captured I/O base address |
| cfg_a | output | 16 | First captured configuration word |
| cfg_b | output | 16 | Second captured configuration word |
| win_hit | output | 1 | Current access falls in the 32-byte window |

## Verification
The assertions take for granted that `io_dp` marks exactly one cycle per access. They also assume the bus fields are stable in that cycle, so one strobe can never be seen twice. The stimulus meets this by raising `io_dp` for a single cycle at a time with idle cycles in between. It mixes correct next bytes, wrong bytes, foreign addresses, reads and cleared lane-0 enables. Address upper bytes are drawn at random while `addr_full` changes between runs, so both compare widths meet near-miss addresses.

// File: rtl/io_reloc_snoop.sv
module io_reloc_snoop #(
  parameter logic [31:0] PORT_ADDR = 32'h0000_0378,
  parameter int          WIN_LOG2  = 5,
  parameter int          SEQ_LEN   = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] bus_addr,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  input  logic        io_wr,
  input  logic        io_dp,
  input  logic        mode_req,
  input  logic        addr_full,
  input  logic        dir_we,
  input  logic        dir_sel,
  input  logic [15:0] dir_data,
  output logic        reloc_mode,
  output logic [31:0] io_base,
  output logic [15:0] cfg_a,
  output logic [15:0] cfg_b,
  output logic        win_hit
);

  localparam int STEP_W = $clog2(SEQ_LEN);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(SEQ_LEN - 1);

  logic [STEP_W-1:0] step;
  logic [7:0]        byte_in;
  logic [7:0]        sig_byte;
  logic              port_hit;
  logic              qual;
  logic              in_sig;
  logic [31:0]       offset;
  logic              unused_ok;

  assign unused_ok = ^{bus_be[3:1], bus_wdata[31:8]};
  assign byte_in   = bus_wdata[7:0];
  assign port_hit  = addr_full ? (bus_addr == PORT_ADDR)
                               : (bus_addr[23:0] == PORT_ADDR[23:0]);
  assign qual      = io_dp && io_wr && bus_be[0] && port_hit;
  assign in_sig    = step < STEP_W'(4);

  always_comb begin
    case (step[1:0])
      2'd0:    sig_byte = 8'h41;
      2'd1:    sig_byte = 8'h4D;
      2'd2:    sig_byte = 8'h44;
      default: sig_byte = 8'h01;
    endcase
  end

  assign offset  = bus_addr - io_base;
  assign win_hit = io_dp && !reloc_mode && (offset[31:WIN_LOG2] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reloc_mode <= 1'b0;
      step       <= '0;
      io_base    <= '0;
      cfg_a      <= '0;
      cfg_b      <= '0;
    end else if (mode_req) begin
      reloc_mode <= 1'b1;
      step       <= '0;
    end else if (reloc_mode) begin
      if (io_dp) begin
        if (!qual) begin
          step <= '0;
        end else if (in_sig) begin
          if (byte_in == sig_byte)   step <= step + 1'b1;
          else if (byte_in == 8'h41) step <= STEP_W'(1);
          else                       step <= '0;
        end else begin
          case (step)
            STEP_W'(4):  io_base[7:0]   <= byte_in;
            STEP_W'(5):  io_base[15:8]  <= byte_in;
            STEP_W'(6):  io_base[23:16] <= byte_in;
            STEP_W'(7):  io_base[31:24] <= byte_in;
            STEP_W'(8):  cfg_a[7:0]     <= byte_in;
            STEP_W'(9):  cfg_a[15:8]    <= byte_in;
            STEP_W'(10): cfg_b[7:0]     <= byte_in;
            default:     cfg_b[15:8]    <= byte_in;
          endcase
          if (step == LAST) begin
            step       <= '0;
            reloc_mode <= 1'b0;
          end else begin
            step <= step + 1'b1;
          end
        end
      end
    end else if (dir_we) begin
      if (dir_sel) io_base[31:16] <= dir_data;
      else         io_base[15:0]  <= dir_data;
    end
  end

  AST_ENTER_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_req |=> reloc_mode && step == '0); // R2

  AST_SIG_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (reloc_mode && !mode_req && qual && in_sig && byte_in == sig_byte)
      |=> step == $past(step) + 1'b1); // R3

  AST_BREAK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (reloc_mode && !mode_req && io_dp && !qual) |=> step == '0); // R4

  AST_RESYNC_41: assert property (@(posedge clk) disable iff (!rst_n)
    (reloc_mode && !mode_req && qual && in_sig && byte_in != sig_byte && byte_in == 8'h41)
      |=> step == STEP_W'(1)); // R5

  AST_CAPTURE_BASE0: assert property (@(posedge clk) disable iff (!rst_n)
    (reloc_mode && !mode_req && qual && step == STEP_W'(4))
      |=> io_base[7:0] == $past(bus_wdata[7:0])); // R6

  AST_EXIT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (reloc_mode && !mode_req && qual && step == LAST) |=> !reloc_mode); // R8

  AST_DIRECT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (reloc_mode && !io_dp && dir_we) |=> $stable(io_base)); // R10

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !io_dp |=> $stable(step) || step == '0); // R11

  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step <= LAST); // R11

endmodule

// File: tb/test_io_reloc_snoop.sv
module test_io_reloc_snoop;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic        io_wr = 1'b0;
  logic        io_dp = 1'b0;
  logic        mode_req = 1'b0;
  logic        addr_full = 1'b1;
  logic        dir_we = 1'b0;
  logic        dir_sel = 1'b0;
  logic [15:0] dir_data = '0;
  logic        reloc_mode;
  logic [31:0] io_base;
  logic [15:0] cfg_a, cfg_b;
  logic        win_hit;

  int errors = 0;
  int checks = 0;

  logic        m_mode = 1'b0;
  int          m_step = 0;
  logic [31:0] m_base = '0;
  logic [15:0] m_a = '0, m_b = '0;

  io_reloc_snoop i_io_reloc_snoop (.*);

  always #4 clk = ~clk;

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [7:0] sig(int s);
    case (s)
      0: return 8'h41;
      1: return 8'h4D;
      2: return 8'h44;
      default: return 8'h01;
    endcase
  endfunction

  function automatic logic exp_hit(logic [31:0] a);
    logic [31:0] d;
    d = a - m_base;
    return !m_mode && d < 32;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_state(string req);
    chk(req, {reloc_mode, io_base, cfg_a, cfg_b}, {m_mode, m_base, m_a, m_b});
  endtask

  task automatic model_access(logic [31:0] a, logic [3:0] be, logic [31:0] d, logic wr);
    logic pm;
    logic [7:0] b;
    if (!m_mode) return;
    pm = addr_full ? (a == 32'h378) : (a[23:0] == 24'h378);
    b = d[7:0];
    if (!(pm && wr && be[0])) m_step = 0;
    else if (m_step < 4) begin
      if (b == sig(m_step)) m_step++;
      else m_step = (b == 8'h41) ? 1 : 0;
    end else begin
      case (m_step)
        4: m_base[7:0] = b;
        5: m_base[15:8] = b;
        6: m_base[23:16] = b;
        7: m_base[31:24] = b;
        8: m_a[7:0] = b;
        9: m_a[15:8] = b;
        10: m_b[7:0] = b;
        default: m_b[15:8] = b;
      endcase
      if (m_step == 11) begin m_step = 0; m_mode = 1'b0; end
      else m_step++;
    end
  endtask

  task automatic access(string req, logic [31:0] a, logic [3:0] be, logic [31:0] d, logic wr);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; io_wr = wr; io_dp = 1'b1;
    #1;
    chk({req, " hit"}, win_hit, exp_hit(a));
    model_access(a, be, d, wr);
    @(negedge clk);
    io_dp = 1'b0;
    chk_state(req);
  endtask

  task automatic enter_mode();
    @(negedge clk);
    mode_req = 1'b1;
    @(negedge clk);
    mode_req = 1'b0;
    m_mode = 1'b1; m_step = 0;
    chk_state("R2");
  endtask

  task automatic dwrite(logic sel, logic [15:0] d);
    @(negedge clk);
    dir_we = 1'b1; dir_sel = sel; dir_data = d;
    @(negedge clk);
    dir_we = 1'b0;
    if (!m_mode) begin
      if (sel) m_base[31:16] = d; else m_base[15:0] = d;
    end
    chk_state("R10");
  endtask

  task automatic full_seq(string req, logic [31:0] base, logic [15:0] a, logic [15:0] b);
    logic [7:0] pay [8];
    pay = '{base[7:0], base[15:8], base[23:16], base[31:24], a[7:0], a[15:8], b[7:0], b[15:8]};
    for (int i = 0; i < 4; i++) access(req, 32'h378, 4'h1, {24'hABCDEF, sig(i)}, 1'b1);
    for (int i = 0; i < 8; i++) access(req, 32'h378, 4'hF, {24'h123456, pay[i]}, 1'b1);
  endtask

  initial begin
    logic [31:0] r;
    r = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    chk("R1 reset", {reloc_mode, io_base, cfg_a, cfg_b, win_hit}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_state("R1");

    dwrite(1'b0, 16'h0300);
    access("R8 direct window", 32'h31F, 4'h1, 0, 1'b0);
    access("R8 direct miss", 32'h320, 4'h1, 0, 1'b0);

    enter_mode();
    access("R9", 32'h300, 4'h1, 0, 1'b0);
    dwrite(1'b1, 16'hDEAD);
    full_seq("R3 R6", 32'h0000_C200, 16'h1234, 16'hA5F0);
    chk("R8 exit", reloc_mode, 1'b0);
    access("R8 base", 32'hC200, 4'h1, 0, 1'b1);
    access("R8 top", 32'hC21F, 4'h1, 0, 1'b0);
    access("R8 above", 32'hC220, 4'h1, 0, 1'b0);
    access("R8 below", 32'hC1FF, 4'h1, 0, 1'b0);

    enter_mode();
    access("R5", 32'h378, 4'h1, 32'h41, 1'b1);
    access("R5", 32'h378, 4'h1, 32'h4D, 1'b1);
    access("R5 resync", 32'h378, 4'h1, 32'h41, 1'b1);
    access("R5", 32'h378, 4'h1, 32'h4D, 1'b1);
    access("R4 read", 32'h378, 4'h1, 32'h44, 1'b0);
    access("R4 be0", 32'h378, 4'hE, 32'h41, 1'b1);
    access("R4 other", 32'h37C, 4'h1, 32'h41, 1'b1);
    addr_full = 1'b0;
    for (int i = 0; i < 4; i++) access("R7 24bit", 32'h7700_0378, 4'h1, {24'h0, sig(i)}, 1'b1);
    for (int i = 0; i < 8; i++) access("R7 R6", 32'hFF00_0378, 4'h1, 32'h11 * i, 1'b1);
    chk("R7 exit", reloc_mode, 1'b0);
    addr_full = 1'b1;
    enter_mode();
    access("R7 full", 32'h0100_0378, 4'h1, 32'h41, 1'b1);
    access("R7 full", 32'h0000_0378, 4'h1, 32'h4D, 1'b1);

    for (int n = 0; n < 4000; n++) begin
      int k;
      logic [31:0] a;
      logic [7:0] b;
      k = $urandom_range(0, 99);
      if (k < 2) enter_mode();
      else if (k < 4) dwrite(1'($urandom), 16'($urandom));
      else if (k < 5) addr_full = 1'($urandom);
      else begin
        a = $urandom_range(0, 3) == 0 ? {8'($urandom_range(0, 1)), 24'h000378} : 32'h378;
        if ($urandom_range(0, 9) == 0) a = $urandom;
        if (!m_mode && $urandom_range(0, 1) == 1) a = m_base + 32'($urandom_range(0, 40)) - 4;
        b = (m_step < 4 && $urandom_range(0, 9) < 8) ? sig(m_step) : 8'($urandom);
        access("R3 R4 R5 R6 R11 random", a, {3'($urandom), $urandom_range(0, 19) != 0},
               {24'($urandom), b}, $urandom_range(0, 19) != 0);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule